// File: doc/BRIEF.md
# Bus-Master Disk DMA Channel

This block is one channel of a bus-master DMA engine for a legacy disk interface. Software programs a small register window. It sets a pointer to a table of 8-byte descriptors in memory and writes a direction and a start bit. The engine then walks the table on its own. For each descriptor it reads a buffer address and a byte count, and it moves 32-bit words between that buffer and the device data port. It stops after the descriptor that carries the end-of-table marker.

The window holds three registers. A command byte carries the start bit and the direction. A status byte mixes three kinds of bit: write-one-to-clear interrupt and error flags, two per-drive capability bits that software may read and write, and a read-only simplex indication taken from a strap pin. The third register is the 32-bit descriptor pointer. Registers are reached by dword index with byte-lane enables. A second channel would use the same block, with its window decoded 8 bytes higher by the surrounding logic.

When the last descriptor finishes, the channel drops its active flag and raises its interrupt. An interrupt from the device that arrives early also sets the interrupt flag. If the device has stopped requesting data at that moment, the error flag is set as well. Software ends or aborts a run by writing the start bit to 0.

Top module: `bmdma_channel`

## Requirements
- R1: After reset, both register dwords read 0 except status bit 7, which follows `simplex_in`. `irq` is low and no memory request is issued.
- R2: Command byte (dword 0, lane 0): bit 0 is start and bit 3 is direction (1 = device to memory, 0 = memory to device). Both bits read back as written and the other bits read 0. Writing bit 0 = 1 while idle with an aligned pointer makes status bit 0 (active) read 1 on the next read.
- R3: Status byte (dword 0, lane 2): bits 5 and 6 are stored as written and read back. Bit 7 always shows `simplex_in`, and writes to it have no effect. Bits 3 and 4 read 0.
- R4: Status bit 2 (interrupt) and bit 1 (error) are cleared by writing 1. Writing 0 to either bit leaves it unchanged.
- R5: Dword 1 is the 32-bit descriptor pointer, writable per byte lane and readable. A start write while the pointer has bits [1:0] not equal to 0 sets the error flag, leaves active at 0 and issues no memory request.
- R6: A descriptor is two dwords at pointer and pointer+4. The first is the buffer address. In the second, bits [15:0] are the byte count and bit 31 marks the end of the table. Descriptors without the marker are followed by the one 8 bytes higher.
- R7: With direction 1, each word taken from `dev_rdata` (with `dev_dack` high only while `dev_dreq` is high) is written to memory at consecutive word addresses from the buffer address.
- R8: With direction 0, memory words read from consecutive buffer addresses are presented on `dev_wdata`, in order, one per `dev_dack`.
- R9: A count field of 0 moves 65536 bytes (16384 words).
- R10: When the end-of-table descriptor's count is exhausted, active clears and the interrupt sets in the same cycle, so status bits [2:0] read 100b. `irq` is high while the interrupt flag is set.
- R11: A rising edge on `dev_irq` sets the interrupt flag and does not clear active. If it comes while active with `dev_dreq` low, the error flag is also set.
- R12: Writing start = 0 while active clears active on the next cycle. After that there are no memory requests or device acknowledges, and the interrupt flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Dword index in the window (0: command/status, 1: pointer) |
| reg_be | input | 4 | Byte-lane enables for writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the dword selected by `reg_addr` |
| simplex_in | input | 1 | Strap shown as status bit 7 |
| mem_req | output | 1 | Memory access request |
| mem_wr | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Access complete; read data valid in the same cycle |
| mem_rdata | input | 32 | Memory read data |
| dev_dreq | input | 1 | Device ready to move a word |
| dev_dack | output | 1 | A word is moved this cycle |
| dev_rdata | input | 32 | Word from the device |
| dev_wdata | output | 32 | Word to the device |
| dev_irq | input | 1 | Device interrupt |
| irq | output | 1 | Channel interrupt (status bit 2) |

## Verification
The bench walks a two-descriptor table to show the engine follows the chain instead of stopping after the first entry. A design that ignored the end-of-table bit would run off into the next table slot, and one that misread the 8-byte stride would write to the wrong buffers. A count field of 0 is run in full. A design that treats it as zero would finish at once with no words moved, and the acknowledge count shows this. Early device interrupts are raised twice, once with requests stalled and once with them flowing. A design that cleared active on them, or that flagged an error without checking the request line, is caught by the status readback. Two more cases are covered: a misaligned pointer, and a stop written in the middle of a run. Each must leave the memory-request and acknowledge counters frozen, which exposes an engine that keeps running.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

   typedef enum logic [2:0] {
      ENG_IDLE,
      ENG_FETCH_ADDR,
      ENG_FETCH_CNT,
      ENG_DEV_IN,
      ENG_MEM_WR,
      ENG_MEM_RD,
      ENG_DEV_OUT
   } eng_state_e;

   // byte lanes inside dword 0
   localparam int LANE_CMD  = 0;
   localparam int LANE_STAT = 2;

   // command byte fields
   localparam int CMD_GO  = 0;
   localparam int CMD_DIR = 3;

   // status byte fields
   localparam int STS_ACT  = 0;
   localparam int STS_ERR  = 1;
   localparam int STS_INT  = 2;
   localparam int STS_CAP0 = 5;
   localparam int STS_CAP1 = 6;
   localparam int STS_SPX  = 7;

endpackage

// File: rtl/bmdma_prd_unpack.sv
module bmdma_prd_unpack #(
   parameter int CNT_W = 16
) (
   input  logic [CNT_W-1:0] cnt_field,
   input  logic             eot_field,
   output logic [CNT_W:0]   byte_cnt,
   output logic             eot
);
   // a zero count encodes the full 2**CNT_W bytes
   always_comb begin
      if (cnt_field == '0) byte_cnt = {1'b1, {CNT_W{1'b0}}};
      else                 byte_cnt = {1'b0, cnt_field};
      eot = eot_field;
   end
endmodule

// File: rtl/bmdma_engine.sv
module bmdma_engine
   import bmdma_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int CNT_W      = 16,
   parameter int DESC_BYTES = 8,
   parameter int EOT_BIT    = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              stop,
   input  logic              dir,
   input  logic [ADDR_W-1:0] table_ptr,
   output logic              active,
   output logic              done,
   output logic              mem_req,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              dev_dreq,
   output logic              dev_dack,
   input  logic [DATA_W-1:0] dev_rdata,
   output logic [DATA_W-1:0] dev_wdata
);
   localparam int XB    = DATA_W / 8;
   localparam int REM_W = CNT_W + 1;

   eng_state_e        state_q;
   logic [ADDR_W-1:0] desc_q;
   logic [ADDR_W-1:0] buf_q;
   logic [REM_W-1:0]  rem_q;
   logic              eot_q;
   logic              dir_q;
   logic [DATA_W-1:0] data_q;

   logic [REM_W-1:0]  ld_cnt;
   logic              ld_eot;
   logic              step;
   logic              last_word;

   bmdma_prd_unpack #(.CNT_W(CNT_W)) u_unpack (
      .cnt_field (mem_rdata[CNT_W-1:0]),
      .eot_field (mem_rdata[EOT_BIT]),
      .byte_cnt  (ld_cnt),
      .eot       (ld_eot)
   );

   always_comb begin
      active    = (state_q != ENG_IDLE);
      mem_req   = (state_q == ENG_FETCH_ADDR) || (state_q == ENG_FETCH_CNT) ||
                  (state_q == ENG_MEM_WR)     || (state_q == ENG_MEM_RD);
      mem_wr    = (state_q == ENG_MEM_WR);
      case (state_q)
         ENG_FETCH_ADDR: mem_addr = desc_q;
         ENG_FETCH_CNT:  mem_addr = desc_q + ADDR_W'(4);
         default:        mem_addr = buf_q;
      endcase
      mem_wdata = data_q;
      dev_wdata = data_q;
      dev_dack  = ((state_q == ENG_DEV_IN) || (state_q == ENG_DEV_OUT)) && dev_dreq;
      step      = ((state_q == ENG_MEM_WR) && mem_ack) ||
                  ((state_q == ENG_DEV_OUT) && dev_dreq);
      last_word = (rem_q <= REM_W'(XB));
      done      = step && last_word && eot_q && !stop;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ENG_IDLE;
         desc_q  <= '0;
         buf_q   <= '0;
         rem_q   <= '0;
         eot_q   <= 1'b0;
         dir_q   <= 1'b0;
         data_q  <= '0;
      end else if (stop) begin
         state_q <= ENG_IDLE;
      end else begin
         case (state_q)
            ENG_IDLE: if (start) begin
               desc_q  <= table_ptr;
               dir_q   <= dir;
               state_q <= ENG_FETCH_ADDR;
            end
            ENG_FETCH_ADDR: if (mem_ack) begin
               buf_q   <= mem_rdata[ADDR_W-1:0];
               state_q <= ENG_FETCH_CNT;
            end
            ENG_FETCH_CNT: if (mem_ack) begin
               rem_q   <= ld_cnt;
               eot_q   <= ld_eot;
               state_q <= dir_q ? ENG_DEV_IN : ENG_MEM_RD;
            end
            ENG_DEV_IN: if (dev_dreq) begin
               data_q  <= dev_rdata;
               state_q <= ENG_MEM_WR;
            end
            ENG_MEM_RD: if (mem_ack) begin
               data_q  <= mem_rdata;
               state_q <= ENG_DEV_OUT;
            end
            ENG_MEM_WR, ENG_DEV_OUT: if (step) begin
               buf_q <= buf_q + ADDR_W'(XB);
               if (last_word) begin
                  if (eot_q) begin
                     state_q <= ENG_IDLE;
                  end else begin
                     desc_q  <= desc_q + ADDR_W'(DESC_BYTES);
                     state_q <= ENG_FETCH_ADDR;
                  end
               end else begin
                  rem_q   <= rem_q - REM_W'(XB);
                  state_q <= dir_q ? ENG_DEV_IN : ENG_MEM_RD;
               end
            end
            default: state_q <= ENG_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
   import bmdma_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_addr,
   input  logic [3:0]        reg_be,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              simplex_in,
   input  logic              eng_active,
   input  logic              eng_done,
   input  logic              dev_irq,
   input  logic              dev_dreq,
   output logic              start_p,
   output logic              stop_p,
   output logic              dir,
   output logic [ADDR_W-1:0] table_ptr,
   output logic              int_flag
);
   logic       go_q;
   logic       dir_q;
   logic [1:0] cap_q;
   logic       err_q;
   logic       int_q;
   logic       irq_q;
   logic [ADDR_W-1:0] ptr_q;

   logic [7:0] cmd_wb;
   logic [7:0] sts_wb;
   logic       cmd_wr;
   logic       sts_wr;
   logic       go_req;
   logic       misalign;
   logic       irq_rise;
   logic [7:0] cmd_rb;
   logic [7:0] sts_rb;

   always_comb begin
      cmd_wb   = reg_wdata[8*LANE_CMD +: 8];
      sts_wb   = reg_wdata[8*LANE_STAT +: 8];
      cmd_wr   = reg_wr && !reg_addr && reg_be[LANE_CMD];
      sts_wr   = reg_wr && !reg_addr && reg_be[LANE_STAT];
      go_req   = cmd_wr && cmd_wb[CMD_GO] && !eng_active;
      misalign = go_req && (ptr_q[1:0] != 2'b00);
      start_p  = go_req && !misalign;
      stop_p   = cmd_wr && !cmd_wb[CMD_GO] && eng_active;
      irq_rise = dev_irq && !irq_q;
      dir      = cmd_wb[CMD_DIR];
      table_ptr = ptr_q;
      int_flag = int_q;

      cmd_rb = '0;
      cmd_rb[CMD_GO]  = go_q;
      cmd_rb[CMD_DIR] = dir_q;
      sts_rb = '0;
      sts_rb[STS_ACT]  = eng_active;
      sts_rb[STS_ERR]  = err_q;
      sts_rb[STS_INT]  = int_q;
      sts_rb[STS_CAP0] = cap_q[0];
      sts_rb[STS_CAP1] = cap_q[1];
      sts_rb[STS_SPX]  = simplex_in;

      reg_rdata = '0;
      if (reg_addr) begin
         reg_rdata = 32'(ptr_q);
      end else begin
         reg_rdata[8*LANE_CMD +: 8]  = cmd_rb;
         reg_rdata[8*LANE_STAT +: 8] = sts_rb;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         go_q  <= 1'b0;
         dir_q <= 1'b0;
         cap_q <= '0;
         err_q <= 1'b0;
         int_q <= 1'b0;
         irq_q <= 1'b0;
         ptr_q <= '0;
      end else begin
         irq_q <= dev_irq;
         if (cmd_wr) begin
            go_q  <= cmd_wb[CMD_GO];
            dir_q <= cmd_wb[CMD_DIR];
         end
         if (sts_wr) cap_q <= {sts_wb[STS_CAP1], sts_wb[STS_CAP0]};
         // set sources win over a clear in the same cycle
         if (eng_done || irq_rise)
            int_q <= 1'b1;
         else if (sts_wr && sts_wb[STS_INT])
            int_q <= 1'b0;
         if (misalign || (irq_rise && eng_active && !dev_dreq))
            err_q <= 1'b1;
         else if (sts_wr && sts_wb[STS_ERR])
            err_q <= 1'b0;
         if (reg_wr && reg_addr) begin
            for (int b = 0; b < 4; b++)
               if (reg_be[b] && (8*b < ADDR_W)) ptr_q[8*b +: 8] <= reg_wdata[8*b +: 8];
         end
      end
   end
endmodule

// File: rtl/bmdma_channel.sv
module bmdma_channel
   import bmdma_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int CNT_W      = 16,
   parameter int DESC_BYTES = 8,
   parameter int EOT_BIT    = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_addr,
   input  logic [3:0]        reg_be,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              simplex_in,
   output logic              mem_req,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              dev_dreq,
   output logic              dev_dack,
   input  logic [DATA_W-1:0] dev_rdata,
   output logic [DATA_W-1:0] dev_wdata,
   input  logic              dev_irq,
   output logic              irq
);
   generate
      if (ADDR_W != 32) begin : g_bad_addr
         $error("bmdma_channel: pointer register is 32 bits, ADDR_W must be 32");
      end
      if (DATA_W != ADDR_W) begin : g_bad_data
         $error("bmdma_channel: descriptor address dword needs DATA_W == ADDR_W");
      end
      if ((CNT_W < 2) || (CNT_W >= EOT_BIT) || (EOT_BIT >= DATA_W)) begin : g_bad_cnt
         $error("bmdma_channel: count field must sit below the end-of-table bit");
      end
      if (DESC_BYTES != 2 * (DATA_W / 8)) begin : g_bad_desc
         $error("bmdma_channel: a descriptor is two data words");
      end
   endgenerate

   logic              start_p;
   logic              stop_p;
   logic              dir;
   logic [ADDR_W-1:0] table_ptr;
   logic              eng_active;
   logic              eng_done;
   logic              int_flag;

   bmdma_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_addr   (reg_addr),
      .reg_be     (reg_be),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .simplex_in (simplex_in),
      .eng_active (eng_active),
      .eng_done   (eng_done),
      .dev_irq    (dev_irq),
      .dev_dreq   (dev_dreq),
      .start_p    (start_p),
      .stop_p     (stop_p),
      .dir        (dir),
      .table_ptr  (table_ptr),
      .int_flag   (int_flag)
   );

   bmdma_engine #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
      .DESC_BYTES(DESC_BYTES), .EOT_BIT(EOT_BIT)
   ) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start_p),
      .stop      (stop_p),
      .dir       (dir),
      .table_ptr (table_ptr),
      .active    (eng_active),
      .done      (eng_done),
      .mem_req   (mem_req),
      .mem_wr    (mem_wr),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_ack   (mem_ack),
      .mem_rdata (mem_rdata),
      .dev_dreq  (dev_dreq),
      .dev_dack  (dev_dack),
      .dev_rdata (dev_rdata),
      .dev_wdata (dev_wdata)
   );

   assign irq = int_flag;
endmodule

// File: rtl/bmdma_checker.sv
module bmdma_checker #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              reg_addr,
   input logic [3:0]        reg_be,
   input logic [31:0]       reg_wdata,
   input logic              mem_req,
   input logic              dev_dreq,
   input logic              dev_dack,
   input logic              dev_irq,
   input logic              start_p,
   input logic              stop_p,
   input logic              eng_active,
   input logic              eng_done,
   input logic              int_flag,
   input logic [ADDR_W-1:0] table_ptr
);
   assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start_p |=> eng_active);

   assert_misalign_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_addr && reg_be[0] && reg_wdata[0] && !eng_active &&
       (table_ptr[1:0] != 2'b00)) |=> !eng_active);

   assert_dack_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dev_dack |-> dev_dreq);

   assert_done_int_R10: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done |=> (int_flag && !eng_active));

   assert_early_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(dev_irq) && eng_active && !stop_p) |=> (int_flag && eng_active));

   assert_stop_R12: assert property (@(posedge clk) disable iff (!rst_n)
      stop_p |=> !eng_active);

   assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_active |-> (!mem_req && !dev_dack));
endmodule

bind bmdma_channel bmdma_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr     (reg_wr),
   .reg_addr   (reg_addr),
   .reg_be     (reg_be),
   .reg_wdata  (reg_wdata),
   .mem_req    (mem_req),
   .dev_dreq   (dev_dreq),
   .dev_dack   (dev_dack),
   .dev_irq    (dev_irq),
   .start_p    (start_p),
   .stop_p     (stop_p),
   .eng_active (eng_active),
   .eng_done   (eng_done),
   .int_flag   (int_flag),
   .table_ptr  (table_ptr)
);

// File: tb/tb_bmdma_channel.sv
`timescale 1ns/1ps
module tb_bmdma_channel;
   localparam logic [31:0] RD_MASK = 32'h5A5A_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_addr = 1'b0;
   logic [3:0]  reg_be = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        simplex_in = 1'b0;
   logic        mem_req, mem_wr, mem_ack;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        dev_dreq, dev_dack;
   logic [31:0] dev_rdata, dev_wdata;
   logic        dev_irq = 1'b0;
   logic        irq;

   logic        dev_ready = 1'b0;
   logic        clr = 1'b0;
   logic        chk_out = 1'b0;
   logic [31:0] out_base = '0;
   logic [31:0] desc_mem [16];
   logic [31:0] wmem [64];
   int          wr_cnt, req_cnt, dev_idx, out_bad;
   int          n_chk = 0, n_err = 0;
   bit          finished = 1'b0;

   always #5 clk = ~clk;

   bmdma_channel dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .simplex_in(simplex_in), .mem_req(mem_req), .mem_wr(mem_wr),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .dev_dreq(dev_dreq), .dev_dack(dev_dack),
      .dev_rdata(dev_rdata), .dev_wdata(dev_wdata), .dev_irq(dev_irq), .irq(irq)
   );

   // zero-wait memory: descriptors at 0x100, write window at 0x1000, computed read data elsewhere
   assign mem_ack   = mem_req;
   assign mem_rdata = (mem_addr[31:6] == 26'h4) ? desc_mem[mem_addr[5:2]] : (mem_addr ^ RD_MASK);
   assign dev_dreq  = dev_ready;
   assign dev_rdata = 32'hD000_0000 + 32'(dev_idx);

   always @(posedge clk) begin
      if (clr) begin
         for (int i = 0; i < 64; i++) wmem[i] <= '0;
         wr_cnt <= 0; req_cnt <= 0; dev_idx <= 0; out_bad <= 0;
      end else begin
         if (mem_req) req_cnt <= req_cnt + 1;
         if (mem_req && mem_wr) begin
            wr_cnt <= wr_cnt + 1;
            if (mem_addr[31:8] == 24'h10) wmem[mem_addr[7:2]] <= mem_wdata;
         end
         if (dev_dack) begin
            dev_idx <= dev_idx + 1;
            if (chk_out && (dev_wdata !== ((out_base + 32'(dev_idx * 4)) ^ RD_MASK)))
               out_bad <= out_bad + 1;
         end
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [3:0] be, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_be = '0;
   endtask

   task automatic rd(input logic a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic status(output logic [7:0] s);
      logic [31:0] d;
      rd(1'b0, d);
      s = d[23:16];
   endtask

   task automatic clear_counts();
      @(negedge clk) clr = 1'b1;
      @(negedge clk) clr = 1'b0;
   endtask

   task automatic wait_idle(input int limit);
      logic [7:0] s;
      for (int i = 0; i < limit; i++) begin
         @(negedge clk);
         status(s);
         if (!s[0]) break;
      end
   endtask

   task automatic pulse_irq();
      @(negedge clk) dev_irq = 1'b1;
      @(negedge clk) dev_irq = 1'b0;
   endtask

   task automatic test_reset();
      logic [31:0] d;
      rd(1'b0, d); check(d == 32'h0, "R1 dword0", d, 32'h0);
      rd(1'b1, d); check(d == 32'h0, "R1 pointer", d, 32'h0);
      check(irq == 1'b0 && mem_req == 1'b0, "R1 irq/req", {30'h0, irq, mem_req}, 32'h0);
   endtask

   task automatic test_regs();
      logic [31:0] d;
      logic [7:0] s;
      wr(1'b0, 4'b0100, 32'h00FF_0000);
      status(s); check(s == 8'h60, "R3 cap bits, bit7 pin, bits3-4 zero", {24'h0, s}, 32'h60);
      check(s[2:1] == 2'b00, "R4 write of 0 leaves flags", {24'h0, s}, 32'h60);
      simplex_in = 1'b1;
      #1 status(s); check(s == 8'hE0, "R3 simplex strap", {24'h0, s}, 32'hE0);
      simplex_in = 1'b0;
      wr(1'b0, 4'b0001, 32'h0000_00F8);
      rd(1'b0, d); check(d[7:0] == 8'h08 && d[16] == 1'b0, "R2 cmd readback dir only", d, 32'h0060_0008);
      wr(1'b0, 4'b0001, 32'h0);
      wr(1'b1, 4'b1111, 32'h1234_5678);
      wr(1'b1, 4'b0001, 32'h0000_009C);
      rd(1'b1, d); check(d == 32'h1234_569C, "R5 pointer byte lanes", d, 32'h1234_569C);
      wr(1'b0, 4'b0100, 32'h0);
   endtask

   task automatic test_dev_to_mem();
      logic [31:0] d;
      logic [7:0] s;
      desc_mem[0] = 32'h0000_1000; desc_mem[1] = 32'h0000_0008;
      desc_mem[2] = 32'h0000_1020; desc_mem[3] = 32'h8000_000C;
      desc_mem[4] = 32'h0000_1080; desc_mem[5] = 32'h8000_0004;
      clear_counts();
      dev_ready = 1'b1;
      wr(1'b1, 4'b1111, 32'h0000_0100);
      wr(1'b0, 4'b0001, 32'h0000_0009);
      status(s); check(s[0] == 1'b1, "R2 start sets active", {24'h0, s}, 32'h1);
      wait_idle(200);
      status(s); check(s[2:0] == 3'b100, "R10 status after completion", {24'h0, s}, 32'h4);
      check(irq == 1'b1, "R10 irq raised", {31'h0, irq}, 32'h1);
      check(wmem[0] == 32'hD000_0000 && wmem[1] == 32'hD000_0001, "R7 first buffer", wmem[1], 32'hD000_0001);
      check(wmem[8] == 32'hD000_0002 && wmem[9] == 32'hD000_0003 && wmem[10] == 32'hD000_0004,
            "R6 second descriptor buffer", wmem[10], 32'hD000_0004);
      check(wmem[2] == 32'h0 && wmem[32] == 32'h0 && wr_cnt == 5, "R6 stops at end marker", 32'(wr_cnt), 32'd5);
      rd(1'b0, d); check(d[7:0] == 8'h09, "R2 cmd bits held", d, 32'h9);
      wr(1'b0, 4'b0001, 32'h0);
   endtask

   task automatic test_w1c();
      logic [7:0] s;
      wr(1'b0, 4'b0100, 32'h0000_0000);
      status(s); check(s[2] == 1'b1, "R4 int kept on write 0", {24'h0, s}, 32'h4);
      wr(1'b0, 4'b0100, 32'h0004_0000);
      status(s); check(s[2] == 1'b0 && irq == 1'b0, "R4 int cleared on write 1", {24'h0, s}, 32'h0);
   endtask

   task automatic test_mem_to_dev();
      logic [7:0] s;
      desc_mem[0] = 32'h0000_2000; desc_mem[1] = 32'h8000_0010;
      clear_counts();
      out_base = 32'h0000_2000; chk_out = 1'b1;
      wr(1'b1, 4'b1111, 32'h0000_0100);
      wr(1'b0, 4'b0001, 32'h0000_0001);
      wait_idle(200);
      check(dev_idx == 4 && out_bad == 0, "R8 words to device", 32'(out_bad), 32'h0);
      check(wr_cnt == 0, "R8 no memory writes", 32'(wr_cnt), 32'h0);
      status(s); check(s[2:0] == 3'b100, "R10 status after read-out", {24'h0, s}, 32'h4);
      chk_out = 1'b0;
      wr(1'b0, 4'b0001, 32'h0);
      wr(1'b0, 4'b0100, 32'h0006_0000);
   endtask

   task automatic test_misalign();
      logic [7:0] s;
      clear_counts();
      wr(1'b1, 4'b1111, 32'h0000_0102);
      wr(1'b0, 4'b0001, 32'h0000_0001);
      status(s); check(s[1:0] == 2'b10, "R5 misaligned start", {24'h0, s}, 32'h2);
      repeat (4) @(negedge clk);
      check(req_cnt == 0, "R5 no memory request", 32'(req_cnt), 32'h0);
      wr(1'b0, 4'b0001, 32'h0);
      wr(1'b0, 4'b0100, 32'h0002_0000);
      status(s); check(s[1] == 1'b0, "R4 err cleared on write 1", {24'h0, s}, 32'h0);
   endtask

   task automatic test_early_irq_stalled();
      logic [7:0] s;
      desc_mem[0] = 32'h0000_1000; desc_mem[1] = 32'h8000_0008;
      clear_counts();
      dev_ready = 1'b0;
      wr(1'b1, 4'b1111, 32'h0000_0100);
      wr(1'b0, 4'b0001, 32'h0000_0009);
      repeat (5) @(negedge clk);
      pulse_irq();
      status(s); check(s[2:0] == 3'b111, "R11 stalled irq: int+err, active", {24'h0, s}, 32'h7);
      wr(1'b0, 4'b0001, 32'h0);
      status(s); check(s[0] == 1'b0 && wr_cnt == 0, "R12 stop clears active", {24'h0, s}, 32'h6);
      wr(1'b0, 4'b0100, 32'h0006_0000);
   endtask

   task automatic test_early_irq_flowing();
      logic [7:0] s;
      int acks;
      desc_mem[0] = 32'h0003_0000; desc_mem[1] = 32'h8000_0000;
      clear_counts();
      dev_ready = 1'b1;
      wr(1'b1, 4'b1111, 32'h0000_0100);
      wr(1'b0, 4'b0001, 32'h0000_0001);
      repeat (20) @(negedge clk);
      pulse_irq();
      status(s); check(s[2:0] == 3'b101, "R11 flowing irq: int only, active", {24'h0, s}, 32'h5);
      wr(1'b0, 4'b0100, 32'h0004_0000);
      wr(1'b0, 4'b0001, 32'h0);
      status(s); check(s[2:0] == 3'b000, "R12 stop: inactive, no int", {24'h0, s}, 32'h0);
      acks = dev_idx;
      repeat (20) @(negedge clk);
      check(dev_idx == acks && !mem_req, "R12 quiet after stop", 32'(dev_idx), 32'(acks));
   endtask

   task automatic test_full_count();
      logic [7:0] s;
      desc_mem[0] = 32'h0003_0000; desc_mem[1] = 32'h8000_0000;
      clear_counts();
      out_base = 32'h0003_0000; chk_out = 1'b1;
      wr(1'b1, 4'b1111, 32'h0000_0100);
      wr(1'b0, 4'b0001, 32'h0000_0001);
      wait_idle(40000);
      check(dev_idx == 16384, "R9 zero count moves 65536 bytes", 32'(dev_idx), 32'd16384);
      check(out_bad == 0, "R9 data across 64 KB", 32'(out_bad), 32'h0);
      status(s); check(s[2:0] == 3'b100, "R10 status after full count", {24'h0, s}, 32'h4);
      chk_out = 1'b0;
      wr(1'b0, 4'b0001, 32'h0);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) desc_mem[i] = '0;
      clr = 1'b1;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      clr = 1'b0;
      @(negedge clk);
      test_reset();
      test_regs();
      test_dev_to_mem();
      test_w1c();
      test_mem_to_dev();
      test_misalign();
      test_early_irq_stalled();
      test_early_irq_flowing();
      test_full_count();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=%h expected=%h", 32'h0, 32'h1);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule